// File: doc/BRIEF.md
# Microprogram Sequencer with Condition Select

This block steps through a small microprogram and supplies the datapath with one control word per clock. A control address register points into a 64-entry store of 26-bit microinstructions. The low sixteen bits of the addressed word go out, registered, as the processor control word. The upper ten bits decide where the address register goes next. A 3-bit field picks one of eight branch conditions: the constants 0 and 1, the carry flag and its inverse, the zero flag and its inverse, the sign flag, and the overflow flag. When the picked condition is true, the register loads a new address. Otherwise it advances by one.

A single source bit chooses where a loaded address comes from: the microinstruction's own next-address field, or an external mapped start address such as the output of an opcode map. The store is synthesizable flip-flop memory with a write port. The environment fills it while the block is held in reset.

Top module: `microseq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the address register and `ctrlWord` are both cleared to 0 on that edge.
- R2: Microinstruction bits [15:0] are the control word. On each edge out of reset, `ctrlWord` takes bits [15:0] of the word the address register pointed at before the edge, so it lags `carOut` by one cycle.
- R3: Condition code 0 in bits [19:17] never branches, so the address register increments by one.
- R4: Condition code 1 always branches. With bit 16 at 0, the address register loads bits [25:20] of the current word.
- R5: Code 2 branches when `flagC` is 1, and code 3 branches when `flagC` is 0.
- R6: Code 4 branches when `flagZ` is 1, and code 5 branches when `flagZ` is 0.
- R7: Code 6 branches when `flagS` is 1, and code 7 branches when `flagV` is 1.
- R8: When a branch is taken and bit 16 is 1, the address register loads `extAddr` instead of bits [25:20].
- R9: Incrementing from address 63 wraps to address 0.
- R10: When the selected condition is false, bit 16, `extAddr` and bits [25:20] have no effect, and the register increments.
- R11: When `progWe` is high at a rising edge, `progData` is written to store entry `progAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| progWe | input | 1 | Write strobe for the microinstruction store |
| progAddr | input | 6 | Store entry to write |
| progData | input | 26 | Microinstruction to write |
| flagC | input | 1 | Carry status flag |
| flagZ | input | 1 | Zero status flag |
| flagS | input | 1 | Sign status flag |
| flagV | input | 1 | Overflow status flag |
| extAddr | input | 6 | External mapped start address |
| ctrlWord | output | 16 | Registered processor control word |
| carOut | output | 6 | Current control address |

## Verification
Every branch decision depends on the word the address register points at, so it is hard to reach each condition code under each flag pattern from the ports. The bench gets there by rewriting entry 0 while reset holds the register at 0. It then releases reset for exactly one edge and reads the next address. This single-step sweep covers all eight codes, all sixteen flag patterns and both address sources. A separate straight-line run over a fully written store checks the control-word lag and the wrap from 63 to 0.

// File: rtl/microseq_pkg.sv
package microseq_pkg;

  // Branch condition codes, order fixed by the condition multiplexer
  typedef enum logic [2:0] {
    CND_NEVER  = 3'd0,
    CND_ALWAYS = 3'd1,
    CND_CARRY  = 3'd2,
    CND_NCARRY = 3'd3,
    CND_ZERO   = 3'd4,
    CND_NZERO  = 3'd5,
    CND_SIGN   = 3'd6,
    CND_OVFL   = 3'd7
  } condCode_e;

  localparam int unsigned COND_W = 3;
  localparam int unsigned NUM_COND = 1 << COND_W;

  // Strobes from the control side to the address datapath
  typedef struct packed {
    logic loadCar;  // branch taken: load instead of increment
    logic useExt;   // loaded address comes from the external input
  } seqStrobe_t;

endpackage

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
  import microseq_pkg::*;
(
  input  logic [COND_W-1:0] condSel,
  input  logic              srcSel,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic              flagS,
  input  logic              flagV,
  output seqStrobe_t        strobe
);

  logic [NUM_COND-1:0] condVec;

  // One entry per condition code, indexed by the code value
  genvar gi;
  generate
    for (gi = 0; gi < NUM_COND; gi++) begin : g_cond
      always_comb begin
        unique case (condCode_e'(gi))
          CND_NEVER:  condVec[gi] = 1'b0;
          CND_ALWAYS: condVec[gi] = 1'b1;
          CND_CARRY:  condVec[gi] = flagC;
          CND_NCARRY: condVec[gi] = ~flagC;
          CND_ZERO:   condVec[gi] = flagZ;
          CND_NZERO:  condVec[gi] = ~flagZ;
          CND_SIGN:   condVec[gi] = flagS;
          default:    condVec[gi] = flagV;
        endcase
      end
    end
  endgenerate

  always_comb begin
    strobe.loadCar = condVec[condSel];
    strobe.useExt  = srcSel;
  end

endmodule

// File: rtl/microseq_dp.sv
module microseq_dp
  import microseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned WORD_W = CTRL_W + 1 + COND_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [WORD_W-1:0] progData,
  input  logic [ADDR_W-1:0] extAddr,
  input  seqStrobe_t        strobe,
  output logic [WORD_W-1:0] romWord,
  output logic [ADDR_W-1:0] car,
  output logic [CTRL_W-1:0] ctrlWord
);

  localparam int unsigned DEPTH    = 1 << ADDR_W;
  localparam int unsigned NEXT_LSB = CTRL_W + 1 + COND_W;

  logic [WORD_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] nextField;
  logic [ADDR_W-1:0] loadAddr;
  logic [ADDR_W-1:0] carNext;

  always_ff @(posedge clk) begin
    if (progWe) store[progAddr] <= progData;
  end

  assign romWord   = store[car];
  assign nextField = romWord[NEXT_LSB +: ADDR_W];
  assign loadAddr  = strobe.useExt ? extAddr : nextField;
  assign carNext   = strobe.loadCar ? loadAddr : ADDR_W'(car + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      car      <= '0;
      ctrlWord <= '0;
    end else begin
      car      <= carNext;
      ctrlWord <= romWord[CTRL_W-1:0];
    end
  end

endmodule

// File: rtl/microseq.sv
module microseq
  import microseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTRL_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  progWe,
  input  logic [ADDR_W-1:0]                     progAddr,
  input  logic [CTRL_W+1+COND_W+ADDR_W-1:0]     progData,
  input  logic                                  flagC,
  input  logic                                  flagZ,
  input  logic                                  flagS,
  input  logic                                  flagV,
  input  logic [ADDR_W-1:0]                     extAddr,
  output logic [CTRL_W-1:0]                     ctrlWord,
  output logic [ADDR_W-1:0]                     carOut
);

  localparam int unsigned WORD_W = CTRL_W + 1 + COND_W + ADDR_W;

  logic [WORD_W-1:0] romWord;
  seqStrobe_t        strobe;

  microseq_ctrl uCtrl (
    .condSel (romWord[CTRL_W+1 +: COND_W]),
    .srcSel  (romWord[CTRL_W]),
    .flagC   (flagC),
    .flagZ   (flagZ),
    .flagS   (flagS),
    .flagV   (flagV),
    .strobe  (strobe)
  );

  microseq_dp #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .WORD_W(WORD_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .extAddr  (extAddr),
    .strobe   (strobe),
    .romWord  (romWord),
    .car      (carOut),
    .ctrlWord (ctrlWord)
  );

endmodule

// File: rtl/microseq_chk.sv
module microseq_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTRL_W = 16
) (
  input logic                           clk,
  input logic                           rst,
  input logic [CTRL_W+4+ADDR_W-1:0]     romWord,
  input logic [ADDR_W-1:0]              extAddr,
  input logic [ADDR_W-1:0]              carOut,
  input logic [CTRL_W-1:0]              ctrlWord
);

  localparam int unsigned NEXT_LSB = CTRL_W + 4;

  logic [2:0]        condF;
  logic              srcF;
  logic [ADDR_W-1:0] nextF;
  assign condF = romWord[CTRL_W+1 +: 3];
  assign srcF  = romWord[CTRL_W];
  assign nextF = romWord[NEXT_LSB +: ADDR_W];

  // R1: reset clears address and control word
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (carOut == '0 && ctrlWord == '0));

  // R2: control word lags the addressed word by one cycle
  p_ctrl_lag_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ctrlWord == $past(romWord[CTRL_W-1:0]));

  // R3: condition code 0 steps by one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    condF == 3'd0 |=> carOut == ADDR_W'($past(carOut) + 1'b1));

  // R4: condition code 1 with field source jumps to next-address field
  p_jump_r4: assert property (@(posedge clk) disable iff (rst)
    (condF == 3'd1 && !srcF) |=> carOut == $past(nextF));

  // R8: condition code 1 with external source loads the external address
  p_ext_load_r8: assert property (@(posedge clk) disable iff (rst)
    (condF == 3'd1 && srcF) |=> carOut == $past(extAddr));

endmodule

bind microseq microseq_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .romWord  (romWord),
  .extAddr  (extAddr),
  .carOut   (carOut),
  .ctrlWord (ctrlWord)
);

// File: tb/microseq_test.sv
module microseq_test;

  localparam int PERIOD = 10;
  localparam int AW = 6;
  localparam int CW = 16;
  localparam int WW = 26;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          progWe = 1'b0;
  logic [AW-1:0] progAddr = '0;
  logic [WW-1:0] progData = '0;
  logic          flagC = 1'b0, flagZ = 1'b0, flagS = 1'b0, flagV = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic [CW-1:0] ctrlWord;
  logic [AW-1:0] carOut;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  microseq uut (
    .clk(clk), .rst(rst), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .flagC(flagC), .flagZ(flagZ), .flagS(flagS),
    .flagV(flagV), .extAddr(extAddr), .ctrlWord(ctrlWord), .carOut(carOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mkWord(input logic [AW-1:0] nxt, input logic [2:0] cnd,
                                           input logic src, input logic [CW-1:0] cw);
    return {nxt, cnd, src, cw};
  endfunction

  function automatic logic [CW-1:0] patCtrl(input int a);
    return CW'((a * 16'h0453) ^ 16'hC3A5);
  endfunction

  function automatic logic condTrue(input int k, input logic [3:0] f);
    case (k)
      0: return 1'b0;
      1: return 1'b1;
      2: return f[0];
      3: return !f[0];
      4: return f[1];
      5: return !f[1];
      6: return f[2];
      default: return f[3];
    endcase
  endfunction

  function automatic string tagOf(input int k, input logic taken, input logic src);
    if (src && taken) return "R8";
    if (src && !taken) return "R10";
    case (k)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4, 5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Write one entry; called at a negedge, returns at the next negedge
  task automatic progEntry(input int a, input logic [WW-1:0] w);
    progWe = 1'b1; progAddr = AW'(a); progData = w;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Fill the store with sequential-step words (R11 checked through ctrlWord)
    for (int a = 0; a < DEPTH; a++) progEntry(a, mkWord(AW'(63 - a), 3'd0, 1'b0, patCtrl(a)));
    check("R1 car after reset", 32'(carOut), 32'd0);
    check("R1 ctrl after reset", 32'(ctrlWord), 32'd0);

    // Straight-line run: step, lag and wrap (R2, R3, R9, R11)
    rst = 1'b0;
    for (int i = 1; i <= 70; i++) begin
      @(negedge clk);
      check((i % 64 == 0) ? "R9 wrap" : "R3 step", 32'(carOut), 32'(i % 64));
      check("R2/R11 ctrl lag", 32'(ctrlWord), 32'(patCtrl((i - 1) % 64)));
    end
    rst = 1'b1;
    @(negedge clk);

    // Single-step sweep over every condition, flag pattern and source
    for (int k = 0; k < 8; k++) begin
      for (int f = 0; f < 16; f++) begin
        for (int s = 0; s < 2; s++) begin
          logic [CW-1:0] cw;
          logic [AW-1:0] nxt;
          logic [AW-1:0] ext;
          logic taken;
          logic [AW-1:0] expCar;
          cw  = CW'(16'h1357 + k * 16'h0101 + f * 16'h0011 + s);
          nxt = AW'(6'h2A ^ (f + k));
          ext = AW'(6'h15 + 3 * f + k);
          progEntry(0, mkWord(nxt, 3'(k), s[0], cw));
          flagC = f[0]; flagZ = f[1]; flagS = f[2]; flagV = f[3];
          extAddr = ext;
          rst = 1'b0;
          @(negedge clk);
          taken  = condTrue(k, 4'(f));
          expCar = taken ? (s[0] ? ext : nxt) : AW'(1);
          check(tagOf(k, taken, s[0]), 32'(carOut), 32'(expCar));
          check("R2 single step ctrl", 32'(ctrlWord), 32'(cw));
          rst = 1'b1;
        end
      end
    end

    @(negedge clk);
    check("R1 car held in reset", 32'(carOut), 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule